// File: doc/BRIEF.md
# Multi-Log Event Interrupt Dispatcher

This block turns the state of several device event logs into a serialized stream of message-signalled interrupt notifications. Five logs are served: informational (index 0), warning (1), failure (2), fatal (3) and dynamic capacity (4). Each log owns an interrupt vector number. All vectors are assigned together when an init strobe samples a base value. Logs 0 to 3 get consecutive numbers. The dynamic-capacity log always reuses the informational log's number.

When a trigger arrives, the dispatcher walks the logs from index 0 upward. It offers one notification for every log that has its interrupt enabled and holds at least one record. Each notification carries that log's vector and the path on which it should travel. The extended table mode takes priority over plain MSI. With neither mode enabled, nothing is sent, because no legacy wire interrupt exists. Notifications leave on a valid/ready interface. A trigger that arrives during a walk is remembered and produces one more complete walk. Forming the bus message is left to a downstream block.

Top module: `evt_irq_dispatch`

## Requirements
- R1: One clock edge after `init_strobe`, log i (i = 0..3) holds vector `(init_base + i) mod 2048`. Vectors change only on `init_strobe`. After reset they hold the values for a base of 0.
- R2: The dynamic-capacity log (index 4) always carries the same vector as the informational log (index 0), both after reset and after every init.
- R3: The per-log interrupt enables reset to all-disabled. They take `en_value` (bit i enables log i) only on a cycle with `en_load` high. While the enables are disabled, a trigger produces no notification.
- R4: One walk produces exactly one notification for each log whose enable bit and `log_nonempty` bit are both 1, in ascending index order. Logs with either bit at 0 are skipped.
- R5: `note_path` is 1 (extended table path) when `msix_on` is 1, and 0 (MSI path) when only `msi_on` is 1. When both are 0, `note_valid` stays low.
- R6: While `note_valid` is high and `note_ready` is low, the offered vector does not change and the walk does not advance. Each accepted handshake yields exactly one notification.
- R7: Triggers that arrive during a walk are merged into one pending request. That request starts one additional full walk from index 0 right after the current walk ends.
- R8: The walk examines log 0 in the cycle after the trigger is sampled, and examines one log per cycle when that log is skipped or its notification is accepted at once. After the last log, the dispatcher goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_strobe | input | 1 | Samples `init_base` and reassigns all vectors |
| init_base | input | 11 | First vector number |
| en_load | input | 1 | Loads the per-log interrupt enables |
| en_value | input | 5 | New enable bits, bit i for log i |
| log_nonempty | input | 5 | Bit i set when log i holds records |
| msix_on | input | 1 | Extended table interrupt mode enabled |
| msi_on | input | 1 | Plain MSI mode enabled |
| trigger | input | 1 | Requests a walk over all logs |
| note_valid | output | 1 | A notification is offered |
| note_ready | input | 1 | Downstream accepts the notification |
| note_vector | output | 11 | Vector of the offered notification |
| note_path | output | 1 | 1 = extended table path, 0 = MSI path |

## Verification
A new vector set is visible one edge after `init_strobe`. A trigger driven before an edge puts log 0 under examination after that edge, and each skipped log adds exactly one cycle. The timing test therefore samples `note_valid` at the falling edge after the first, second and third rising edges. Inputs change one time unit after a rising edge and outputs are read at the falling edge, so each handshake is recorded exactly once. For walk contents, the bench records every accepted handshake and then waits a bound far longer than two walks under random backpressure. It then compares the recorded list against a list built from the enables, non-empty flags and modes it applied.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  typedef enum logic {
    PATH_MSI  = 1'b0,
    PATH_MSIX = 1'b1
  } irq_path_e;

  // Sequential vector for one log; the caller truncates to its width.
  function automatic int unsigned seq_vector(int unsigned base, int unsigned idx);
    return base + idx;
  endfunction

  // Extended table mode wins over plain MSI.
  function automatic irq_path_e pick_path(logic msix_en);
    return msix_en ? PATH_MSIX : PATH_MSI;
  endfunction

  function automatic logic any_mode(logic msix_en, logic msi_en);
    return msix_en | msi_en;
  endfunction

endpackage

// File: rtl/evt_vec_table.sv
module evt_vec_table #(
  parameter int NUM_LOGS  = 5,
  parameter int VEC_W     = 11,
  parameter int SRC_IDX   = 0,
  parameter int ALIAS_IDX = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           init_strobe,
  input  logic [VEC_W-1:0]               init_base,
  output logic [NUM_LOGS-1:0][VEC_W-1:0] vec_q
);
  import evt_irq_pkg::*;

  localparam int CHK_IDX = (ALIAS_IDX == NUM_LOGS - 1) ? NUM_LOGS - 2 : NUM_LOGS - 1;

  for (genvar i = 0; i < NUM_LOGS; i++) begin : g_vec
    localparam int OFS = (i == ALIAS_IDX) ? SRC_IDX : i;
    always_ff @(posedge clk) begin
      if (!rst_n)
        vec_q[i] <= VEC_W'(seq_vector(0, OFS));
      else if (init_strobe)
        vec_q[i] <= VEC_W'(seq_vector(int'(init_base), OFS));
    end
  end

  // R1
  init_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_strobe |=> vec_q[CHK_IDX] == VEC_W'($past(init_base) + VEC_W'(CHK_IDX)));
  // R1
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_strobe |=> $stable(vec_q));
  // R2
  alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_strobe |=> vec_q[ALIAS_IDX] == vec_q[SRC_IDX]);

endmodule

// File: rtl/evt_en_reg.sv
module evt_en_reg #(
  parameter int NUM_LOGS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_load,
  input  logic [NUM_LOGS-1:0] en_value,
  output logic [NUM_LOGS-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      en_q <= '0;
    else if (en_load)
      en_q <= en_value;
  end

  // R3
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_load |=> $stable(en_q));
  // R3
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_load |=> en_q == $past(en_value));

endmodule

// File: rtl/evt_scan.sv
module evt_scan #(
  parameter int NUM_LOGS = 5,
  localparam int IDX_W   = (NUM_LOGS > 1) ? $clog2(NUM_LOGS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trigger,
  input  logic [NUM_LOGS-1:0] en,
  input  logic [NUM_LOGS-1:0] nonempty,
  input  logic                mode_any,
  input  logic                ready,
  output logic                offer,
  output logic [IDX_W-1:0]    idx_q,
  output logic                busy_q
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_LOGS - 1);

  logic pend_q;
  logic step, last, scan_done, restart;

  assign offer     = busy_q & en[idx_q] & nonempty[idx_q] & mode_any;
  assign step      = busy_q & (~offer | ready);
  assign last      = (idx_q == LAST);
  assign scan_done = step & last;
  assign restart   = pend_q | trigger;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (trigger) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end
    end else begin
      if (scan_done) begin
        idx_q  <= '0;
        pend_q <= 1'b0;
        busy_q <= restart;
      end else begin
        if (step)
          idx_q <= idx_q + 1'b1;
        if (trigger)
          pend_q <= 1'b1;
      end
    end
  end

  // R8
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && trigger |=> busy_q && idx_q == '0);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offer && !ready |=> busy_q && idx_q == $past(idx_q));
  // R4
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !last |=> idx_q == $past(idx_q) + 1'b1);
  // R7
  rescan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done && restart |=> busy_q && idx_q == '0);
  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done && !restart |=> !busy_q);

endmodule

// File: rtl/evt_irq_dispatch.sv
module evt_irq_dispatch #(
  parameter int NUM_LOGS  = 5,
  parameter int VEC_W     = 11,
  parameter int INFO_IDX  = 0,
  parameter int SHARE_IDX = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_strobe,
  input  logic [VEC_W-1:0]    init_base,
  input  logic                en_load,
  input  logic [NUM_LOGS-1:0] en_value,
  input  logic [NUM_LOGS-1:0] log_nonempty,
  input  logic                msix_on,
  input  logic                msi_on,
  input  logic                trigger,
  output logic                note_valid,
  input  logic                note_ready,
  output logic [VEC_W-1:0]    note_vector,
  output logic                note_path
);
  import evt_irq_pkg::*;

  localparam int IDX_W = (NUM_LOGS > 1) ? $clog2(NUM_LOGS) : 1;

  logic [NUM_LOGS-1:0][VEC_W-1:0] vec_q;
  logic [NUM_LOGS-1:0]            en_q;
  logic [IDX_W-1:0]               cur_idx;
  logic                           scan_busy;
  logic                           offer;
  irq_path_e                      path_sel;

  evt_vec_table #(
    .NUM_LOGS (NUM_LOGS),
    .VEC_W    (VEC_W),
    .SRC_IDX  (INFO_IDX),
    .ALIAS_IDX(SHARE_IDX)
  ) u_vec (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_strobe(init_strobe),
    .init_base  (init_base),
    .vec_q      (vec_q)
  );

  evt_en_reg #(.NUM_LOGS(NUM_LOGS)) u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_load (en_load),
    .en_value(en_value),
    .en_q    (en_q)
  );

  evt_scan #(.NUM_LOGS(NUM_LOGS)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .trigger (trigger),
    .en      (en_q),
    .nonempty(log_nonempty),
    .mode_any(any_mode(msix_on, msi_on)),
    .ready   (note_ready),
    .offer   (offer),
    .idx_q   (cur_idx),
    .busy_q  (scan_busy)
  );

  assign path_sel    = pick_path(msix_on);
  assign note_valid  = offer;
  assign note_vector = vec_q[cur_idx];
  assign note_path   = path_sel;

  // R5
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid |-> (msix_on || msi_on));
  // R5
  msix_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid && msix_on |-> note_path);
  // R6
  vec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid && !note_ready && !init_strobe |=> $stable(note_vector));
  // R4
  busy_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid |-> scan_busy);

endmodule

// File: tb/evt_irq_dispatch_bench.sv
module evt_irq_dispatch_bench;
  localparam int NL = 5;
  localparam int VW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          init_strobe = 1'b0;
  logic [VW-1:0] init_base = '0;
  logic          en_load = 1'b0;
  logic [NL-1:0] en_value = '0;
  logic [NL-1:0] log_nonempty = '0;
  logic          msix_on = 1'b0;
  logic          msi_on = 1'b0;
  logic          trigger = 1'b0;
  logic          note_valid;
  logic          note_ready = 1'b1;
  logic [VW-1:0] note_vector;
  logic          note_path;

  int checks = 0;
  int fails  = 0;
  int rdy_mode = 0;          // 0: always ready, 1: random, 2: stalled
  int cap_n = 0;
  logic [VW-1:0] cap_vec [0:31];
  logic          cap_path[0:31];
  logic [VW-1:0] m_base = '0;
  logic [NL-1:0] m_en = '0;

  always #4 clk = ~clk;

  evt_irq_dispatch u_evt_irq_dispatch (
    .clk(clk), .rst_n(rst_n), .init_strobe(init_strobe), .init_base(init_base),
    .en_load(en_load), .en_value(en_value), .log_nonempty(log_nonempty),
    .msix_on(msix_on), .msi_on(msi_on), .trigger(trigger),
    .note_valid(note_valid), .note_ready(note_ready),
    .note_vector(note_vector), .note_path(note_path)
  );

  always @(posedge clk) begin
    #1;
    if (rdy_mode == 0)      note_ready = 1'b1;
    else if (rdy_mode == 1) note_ready = ($urandom % 4) != 0;
    else                    note_ready = 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n && note_valid && note_ready && cap_n < 32) begin
      cap_vec[cap_n]  = note_vector;
      cap_path[cap_n] = note_path;
      cap_n = cap_n + 1;
    end
  end

  // Vector a log should carry: log 4 mirrors log 0, others count up mod 2048.
  function automatic int exp_vec(int base, int i);
    if (i == 4) return base % 2048;
    return (base + i) % 2048;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_init(logic [VW-1:0] b);
    tick(); init_base = b; init_strobe = 1'b1;
    tick(); init_strobe = 1'b0;
    m_base = b;
  endtask

  task automatic set_en(logic [NL-1:0] v);
    tick(); en_value = v; en_load = 1'b1;
    tick(); en_load = 1'b0;
    m_en = v;
  endtask

  task automatic run_scan(bit extra, string req);
    int exp_n;
    int ev[0:31];
    exp_n = 0;
    tick(); cap_n = 0; trigger = 1'b1;
    tick(); trigger = 1'b0;
    if (extra) begin
      tick(); trigger = 1'b1;
      tick(); trigger = 1'b0;
    end
    repeat (120) tick();
    if (msix_on || msi_on) begin
      for (int r = 0; r < (extra ? 2 : 1); r++)
        for (int i = 0; i < NL; i++)
          if (m_en[i] && log_nonempty[i]) begin
            ev[exp_n] = exp_vec(int'(m_base), i);
            exp_n++;
          end
    end
    check(cap_n == exp_n, req, cap_n, exp_n);
    for (int k = 0; k < exp_n && k < cap_n; k++) begin
      check(int'(cap_vec[k]) == ev[k], req, int'(cap_vec[k]), ev[k]);
      check(cap_path[k] == msix_on, "R5", int'(cap_path[k]), int'(msix_on));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7731));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    @(negedge clk);
    check(note_valid == 1'b0, "reset", int'(note_valid), 0);

    // R3: enables reset to disabled, so a full set of nonempty logs is silent
    log_nonempty = '1; msix_on = 1'b1;
    run_scan(1'b0, "R3");

    // R1 R2: reset vectors follow base 0, dynamic capacity shares log 0
    set_en('1);
    run_scan(1'b0, "R1");

    // R1: base changes without a strobe are ignored
    tick(); init_base = 11'd500;
    run_scan(1'b0, "R1");

    // R1 R2: wrap around the 11-bit vector space
    do_init(11'd2046);
    run_scan(1'b0, "R2");

    // R5: MSI only, then neither mode
    msix_on = 1'b0; msi_on = 1'b1;
    run_scan(1'b0, "R5");
    msi_on = 1'b0;
    run_scan(1'b0, "R5");
    msix_on = 1'b1; msi_on = 1'b1;
    run_scan(1'b0, "R5");

    // R8: only log 2 eligible, offered three edges after the trigger edge
    do_init(11'd40);
    set_en(5'b00100);
    tick(); trigger = 1'b1;
    tick(); trigger = 1'b0;
    @(negedge clk); check(note_valid == 1'b0, "R8", int'(note_valid), 0);
    @(negedge clk); check(note_valid == 1'b0, "R8", int'(note_valid), 0);
    @(negedge clk); check(note_valid == 1'b1, "R8", int'(note_valid), 1);
    check(note_vector == 11'd42, "R8", int'(note_vector), 42);
    repeat (10) tick();
    @(negedge clk); check(note_valid == 1'b0, "R8", int'(note_valid), 0);

    // R6: stalled downstream holds the first offer
    set_en('1);
    rdy_mode = 2;
    tick(); cap_n = 0; trigger = 1'b1;
    tick(); trigger = 1'b0;
    repeat (5) begin
      @(negedge clk);
      check(note_valid == 1'b1 && note_vector == 11'd40, "R6", int'(note_vector), 40);
    end
    rdy_mode = 0;
    repeat (20) tick();
    check(cap_n == 5, "R6", cap_n, 5);

    // R7: a second trigger during a walk gives one extra full walk
    rdy_mode = 1;
    run_scan(1'b1, "R7");

    // R4: random mixes of enables, nonempty flags, modes and backpressure
    for (int it = 0; it < 40; it++) begin
      if ($urandom % 2) do_init(VW'($urandom));
      set_en(NL'($urandom));
      log_nonempty = NL'($urandom);
      msix_on = ($urandom % 3) != 0;
      msi_on  = ($urandom % 2) != 0;
      run_scan(($urandom % 4) == 0, "R4");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule